// File: doc/BRIEF.md
# Dual Register-Mapped Receive/Transmit Device

This block places two small devices behind one synchronous register bus. The receive side captures a byte offered on a strobe. It raises a ready flag and an interrupt level, and it remembers when a byte was lost because software had not yet consumed the previous one. The transmit side holds a word loaded by software. When software arms it, the block launches the word toward a downstream sender with a one-cycle start pulse. It disarms itself when the sender reports completion, and it signals through a ready flag and an interrupt level that it can take the next word.

Software polls or services interrupts through byte-addressed registers. Some status bits are cleared only by software and others only by hardware. Every output, including read data and both interrupt lines, comes straight from a flop.

Top module: `mmio_dev_pair`

## Requirements
- R1: After synchronous reset the receive status (0xA0) and receive data (0xA1) read 0x0000, the transmit status (0xB0) reads 0x0001 (ready-to-send set, arm bit clear), the transmit word reads 0x0000, irq_in is 0, irq_out is 1 and tx_start is 0.
- R2: A cycle with in_strobe high stores in_byte as the receive data and sets receive status bit 0 (data ready). From the next cycle, irq_in is high and equals bit 0.
- R3: A byte that arrives while bit 0 is already set, and is not being cleared in that cycle, overwrites the receive data and sets sticky receive status bit 1 (overrun).
- R4: A write to 0xA0 with bus_be[0] high clears bit 0 and/or bit 1 where bus_wdata holds a 0 in that position. Writing 1 has no effect, a write with bus_be[0] low has no effect, and writes to 0xA1 are ignored.
- R5: When a byte arrives in the same cycle as a software clear of bit 0, the arrival wins: bit 0 stays 1, the data is the new byte, and overrun is not set by that arrival.
- R6: The 16-bit transmit word sits at 0xB1 (low byte) and 0xB2 (high byte). A write at 0xB1 updates the low byte with bus_be[0] and the high byte from bus_wdata[15:8] with bus_be[1]. A write at 0xB2 updates the high byte from bus_wdata[7:0] with bus_be[0]. A read at 0xB1 returns the full word, and a read at 0xB2 returns the high byte in bits 7:0.
- R7: bus_rdata is registered. It shows the addressed value in the cycle after bus_rd is high, shows 0 for an unmapped address, and is 0 in the cycle after a cycle with no read.
- R8: Writing 0xB0 with bus_be[0] and bus_wdata[1]=1 sets the arm bit (bit 1). One cycle after the bit is set with no transfer in flight, tx_start pulses for exactly one cycle, tx_word carries the transmit word, and ready-to-send clears. Writing 0 to bit 1 has no effect.
- R9: tx_done while a transfer is in flight clears the arm bit and sets ready-to-send. tx_done with no transfer in flight has no effect.
- R10: Writing 0xB0 with bus_be[0] and bus_wdata[0]=0 clears ready-to-send, and writing 1 there has no effect. irq_out equals ready-to-send.
- R11: If software sets the arm bit in the same cycle as tx_done, the arm bit stays set and a new tx_start pulse follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data, two byte lanes |
| bus_be | input | 2 | Byte-lane enables |
| bus_rdata | output | 16 | Registered read data |
| in_strobe | input | 1 | Incoming byte valid |
| in_byte | input | 8 | Incoming byte |
| tx_word | output | 16 | Word handed to the sender |
| tx_start | output | 1 | One-cycle transmission start |
| tx_done | input | 1 | Sender reports completion |
| irq_in | output | 1 | Receive interrupt level |
| irq_out | output | 1 | Transmit interrupt level |

## Verification
Two functions can land on the same edge. The first pair is an incoming byte and a software write that clears data-ready. The bench drives in_strobe and the 0xA0 clear write together in one cycle while the flag is already set. It then judges the outcome by reading the status back as 0x0001 and the data as the new byte. The second pair is tx_done and a software arm write in the same cycle. There the bench expects tx_start to stay low right after that edge and to pulse on the following one.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int LANE_W = 8;

  typedef struct packed {
    logic ovr;
    logic rdy;
  } rx_flags_t;

  typedef struct packed {
    logic arm;
    logic rts;
  } tx_flags_t;
endpackage

// File: rtl/mmio_rx_side.sv
module mmio_rx_side
  import mmio_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              clr_rdy,
  input  logic              clr_ovr,
  output rx_flags_t         flags,
  output logic [BYTE_W-1:0] data
);
  logic lost;

  // a byte is lost only if the previous one is still unconsumed this cycle
  assign lost = strobe & flags.rdy & ~clr_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      data  <= '0;
    end else begin
      if (strobe) data <= byte_in;
      flags.rdy <= strobe | (flags.rdy & ~clr_rdy);
      flags.ovr <= lost | (flags.ovr & ~clr_ovr);
    end
  end

  assert_arrival_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (flags.rdy && data == $past(byte_in)));

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe && flags.rdy && !clr_rdy) |=> flags.ovr);

  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (flags.ovr && !clr_ovr) |=> flags.ovr);

  assert_collision_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe && clr_rdy && !flags.ovr) |=> (flags.rdy && !flags.ovr));
endmodule

// File: rtl/mmio_tx_side.sv
module mmio_tx_side
  import mmio_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WORD_W/LANE_W-1:0] lane_we,
  input  logic [WORD_W-1:0]        lane_wdata,
  input  logic                     set_arm,
  input  logic                     clr_rts,
  input  logic                     tx_done,
  output tx_flags_t                flags,
  output logic [WORD_W-1:0]        word,
  output logic                     tx_start,
  output logic [WORD_W-1:0]        tx_word
);
  localparam int LANES = WORD_W / LANE_W;

  logic busy;
  logic launch;
  logic finish;

  assign launch = flags.arm & ~busy;
  assign finish = busy & tx_done;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst) lane_q <= '0;
        else if (lane_we[k]) lane_q <= lane_wdata[k*LANE_W +: LANE_W];
      end
      assign word[k*LANE_W +: LANE_W] = lane_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.arm <= 1'b0;
      flags.rts <= 1'b1;
      busy      <= 1'b0;
      tx_start  <= 1'b0;
      tx_word   <= '0;
    end else begin
      tx_start  <= launch;
      if (launch) tx_word <= word;
      flags.arm <= (flags.arm & ~finish) | set_arm;
      if (launch)      busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (launch)       flags.rts <= 1'b0;
      else if (finish)  flags.rts <= 1'b1;
      else if (clr_rts) flags.rts <= 1'b0;
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_launch_word_R8: assert property (@(posedge clk) disable iff (rst)
    launch |=> (tx_start && tx_word == $past(word) && !flags.rts));

  assert_done_disarms_R9: assert property (@(posedge clk) disable iff (rst)
    (finish && !set_arm) |=> (!flags.arm && flags.rts));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !flags.rts);

  assert_rearm_R11: assert property (@(posedge clk) disable iff (rst)
    (finish && set_arm) |=> ##1 tx_start);
endmodule

// File: rtl/mmio_read_port.sv
module mmio_read_port
  import mmio_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              BUS_W    = 16,
  parameter int              BYTE_W   = 8,
  parameter int              WORD_W   = 16,
  parameter logic [ADDR_W-1:0] IN_BASE  = 8'hA0,
  parameter logic [ADDR_W-1:0] OUT_BASE = 8'hB0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  rx_flags_t         rx_flags,
  input  logic [BYTE_W-1:0] rx_data,
  input  tx_flags_t         tx_flags,
  input  logic [WORD_W-1:0] word,
  output logic [BUS_W-1:0]  rdata
);
  localparam int LANES = WORD_W / LANE_W;

  logic [BUS_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (addr == IN_BASE)                 nxt = BUS_W'(rx_flags);
    if (addr == ADDR_W'(IN_BASE + 1))    nxt = BUS_W'(rx_data);
    if (addr == OUT_BASE)                nxt = BUS_W'(tx_flags);
    for (int k = 0; k < LANES; k++) begin
      if (addr == ADDR_W'(OUT_BASE + 1 + k)) nxt = BUS_W'(word >> (LANE_W * k));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd ? nxt : '0;
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/mmio_dev_pair.sv
module mmio_dev_pair
  import mmio_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                BUS_W    = 16,
  parameter int                BYTE_W   = 8,
  parameter int                WORD_W   = 16,
  parameter logic [ADDR_W-1:0] IN_BASE  = 8'hA0,
  parameter logic [ADDR_W-1:0] OUT_BASE = 8'hB0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W/8-1:0] bus_be,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              in_strobe,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_start,
  input  logic              tx_done,
  output logic              irq_in,
  output logic              irq_out
);
  localparam int LANES = WORD_W / LANE_W;
  localparam logic [ADDR_W-1:0] WORD_BASE = ADDR_W'(OUT_BASE + 1);

  rx_flags_t         rx_flags;
  tx_flags_t         tx_flags;
  logic [BYTE_W-1:0] rx_data;
  logic [WORD_W-1:0] word;
  logic              wr_rx_st, wr_tx_st;
  logic              clr_rdy, clr_ovr, set_arm, clr_rts;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] lane_wdata;

  assign wr_rx_st = bus_wr & bus_be[0] & (bus_addr == IN_BASE);
  assign wr_tx_st = bus_wr & bus_be[0] & (bus_addr == OUT_BASE);
  assign clr_rdy  = wr_rx_st & ~bus_wdata[0];
  assign clr_ovr  = wr_rx_st & ~bus_wdata[1];
  assign clr_rts  = wr_tx_st & ~bus_wdata[0];
  assign set_arm  = wr_tx_st &  bus_wdata[1];

  // a write at WORD_BASE+j puts lane 0 of the bus into word lane j, lane 1 into j+1
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_wlane
      logic at_k;
      logic below_k;
      assign at_k    = (bus_addr == ADDR_W'(WORD_BASE + k));
      if (k == 0) begin : g_first
        assign below_k = 1'b0;
      end else begin : g_rest
        assign below_k = (bus_addr == ADDR_W'(WORD_BASE + k - 1));
      end
      assign lane_we[k] = bus_wr & ((at_k & bus_be[0]) | (below_k & bus_be[1]));
      assign lane_wdata[k*LANE_W +: LANE_W] = at_k ? bus_wdata[7:0] : bus_wdata[15:8];
    end
  endgenerate

  mmio_rx_side #(.BYTE_W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .strobe  (in_strobe),
    .byte_in (in_byte),
    .clr_rdy (clr_rdy),
    .clr_ovr (clr_ovr),
    .flags   (rx_flags),
    .data    (rx_data)
  );

  mmio_tx_side #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata),
    .set_arm    (set_arm),
    .clr_rts    (clr_rts),
    .tx_done    (tx_done),
    .flags      (tx_flags),
    .word       (word),
    .tx_start   (tx_start),
    .tx_word    (tx_word)
  );

  mmio_read_port #(
    .ADDR_W   (ADDR_W),
    .BUS_W    (BUS_W),
    .BYTE_W   (BYTE_W),
    .WORD_W   (WORD_W),
    .IN_BASE  (IN_BASE),
    .OUT_BASE (OUT_BASE)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .rx_flags (rx_flags),
    .rx_data  (rx_data),
    .tx_flags (tx_flags),
    .word     (word),
    .rdata    (bus_rdata)
  );

  assign irq_in  = rx_flags.rdy;
  assign irq_out = tx_flags.rts;

  logic mapped;
  assign mapped = (bus_addr == IN_BASE) || (bus_addr == ADDR_W'(IN_BASE + 1)) ||
                  ((bus_addr >= OUT_BASE) && (bus_addr <= ADDR_W'(OUT_BASE + LANES)));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  assert_rx_irq_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_strobe |=> irq_in);
endmodule

// File: tb/sim_mmio_dev_pair.sv
`timescale 1ns/1ps
module sim_mmio_dev_pair;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0]  bus_be;
  logic [15:0] bus_rdata;
  logic        in_strobe;
  logic [7:0]  in_byte;
  logic [15:0] tx_word;
  logic        tx_start;
  logic        tx_done;
  logic        irq_in, irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  mmio_dev_pair u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .in_strobe(in_strobe), .in_byte(in_byte), .tx_word(tx_word),
    .tx_start(tx_start), .tx_done(tx_done), .irq_in(irq_in), .irq_out(irq_out)
  );

  // kind: 0 write, 1 read and compare, 2 byte arrival
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [1:0]  be;
    logic [15:0] exp;
    logic [1:0]  irq;   // {irq_out, irq_in} after the step
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'hA0, 16'h0000, 2'b00, 16'h0000, 2'b10, 4'd1},  // R1
    '{2'd1, 8'hB0, 16'h0000, 2'b00, 16'h0001, 2'b10, 4'd1},
    '{2'd1, 8'h55, 16'h0000, 2'b00, 16'h0000, 2'b10, 4'd7},  // R7
    '{2'd2, 8'h00, 16'h005A, 2'b00, 16'h0000, 2'b11, 4'd2},  // R2
    '{2'd1, 8'hA0, 16'h0000, 2'b00, 16'h0001, 2'b11, 4'd2},
    '{2'd1, 8'hA1, 16'h0000, 2'b00, 16'h005A, 2'b11, 4'd2},
    '{2'd2, 8'h00, 16'h00C3, 2'b00, 16'h0000, 2'b11, 4'd3},  // R3
    '{2'd1, 8'hA0, 16'h0000, 2'b00, 16'h0003, 2'b11, 4'd3},
    '{2'd1, 8'hA1, 16'h0000, 2'b00, 16'h00C3, 2'b11, 4'd3},
    '{2'd0, 8'hA1, 16'h00FF, 2'b01, 16'h0000, 2'b11, 4'd4},  // R4
    '{2'd1, 8'hA1, 16'h0000, 2'b00, 16'h00C3, 2'b11, 4'd4},
    '{2'd0, 8'hA0, 16'h0002, 2'b01, 16'h0000, 2'b10, 4'd4},
    '{2'd1, 8'hA0, 16'h0000, 2'b00, 16'h0002, 2'b10, 4'd4},
    '{2'd0, 8'hA0, 16'h0000, 2'b00, 16'h0000, 2'b10, 4'd4},
    '{2'd1, 8'hA0, 16'h0000, 2'b00, 16'h0002, 2'b10, 4'd4},
    '{2'd0, 8'hA0, 16'h0000, 2'b01, 16'h0000, 2'b10, 4'd4},
    '{2'd1, 8'hA0, 16'h0000, 2'b00, 16'h0000, 2'b10, 4'd4},
    '{2'd0, 8'hB1, 16'hBEEF, 2'b11, 16'h0000, 2'b10, 4'd6},  // R6
    '{2'd1, 8'hB1, 16'h0000, 2'b00, 16'hBEEF, 2'b10, 4'd6},
    '{2'd0, 8'hB2, 16'h0012, 2'b01, 16'h0000, 2'b10, 4'd6},
    '{2'd1, 8'hB1, 16'h0000, 2'b00, 16'h12EF, 2'b10, 4'd6},
    '{2'd0, 8'hB1, 16'hAB34, 2'b01, 16'h0000, 2'b10, 4'd6},
    '{2'd1, 8'hB1, 16'h0000, 2'b00, 16'h1234, 2'b10, 4'd6},
    '{2'd1, 8'hB2, 16'h0000, 2'b00, 16'h0012, 2'b10, 4'd6},
    '{2'd0, 8'hB2, 16'h5600, 2'b10, 16'h0000, 2'b10, 4'd6},
    '{2'd1, 8'hB1, 16'h0000, 2'b00, 16'h1234, 2'b10, 4'd6},
    '{2'd0, 8'hB0, 16'h0001, 2'b01, 16'h0000, 2'b10, 4'd10}, // R10
    '{2'd1, 8'hB0, 16'h0000, 2'b00, 16'h0001, 2'b10, 4'd10},
    '{2'd0, 8'hB0, 16'h0000, 2'b01, 16'h0000, 2'b00, 4'd10},
    '{2'd1, 8'hB0, 16'h0000, 2'b00, 16'h0000, 2'b00, 4'd10},
    '{2'd1, 8'hB3, 16'h0000, 2'b00, 16'h0000, 2'b00, 4'd7}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one bus/stimulus cycle, driven at a falling edge and released at the next
  task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                     input logic [15:0] d, input logic [1:0] be,
                     input logic stb, input logic [7:0] b, input logic dn);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_be = be;
    in_strobe = stb; in_byte = b; tx_done = dn;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    in_strobe = 1'b0; in_byte = '0; tx_done = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
    cyc(1'b0, 1'b1, a, 16'h0, 2'b00, 1'b0, 8'h0, 1'b0);
    chk(bus_rdata, exp, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    cyc(1'b1, 1'b0, a, d, be, 1'b0, 8'h0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; bus_be = 0;
    in_strobe = 0; in_byte = 0; tx_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({15'd0, tx_start}, 16'h0, "R1 tx_start after reset");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.kind)
        2'd0: wr(v.addr, v.data, v.be);
        2'd1: cyc(1'b0, 1'b1, v.addr, 16'h0, 2'b00, 1'b0, 8'h0, 1'b0);
        default: cyc(1'b0, 1'b0, 8'h0, 16'h0, 2'b00, 1'b1, v.data[7:0], 1'b0);
      endcase
      if (v.kind == 2'd1)
        chk(bus_rdata, v.exp, $sformatf("R%0d vec %0d rdata", v.req, i));
      chk({14'd0, irq_out, irq_in}, {14'd0, v.irq}, $sformatf("R%0d vec %0d irq", v.req, i));
    end

    // R8: arm, launch one cycle after the arm bit is set
    wr(8'hB0, 16'h0002, 2'b01);
    chk({15'd0, tx_start}, 16'h0, "R8 no start at arm edge");
    @(negedge clk);
    chk({15'd0, tx_start}, 16'h1, "R8 start pulse");
    chk(tx_word, 16'h1234, "R8 tx_word");
    @(negedge clk);
    chk({15'd0, tx_start}, 16'h0, "R8 single pulse");
    rd_chk(8'hB0, 16'h0002, "R8 armed, not ready");
    wr(8'hB0, 16'h0000, 2'b01);
    rd_chk(8'hB0, 16'h0002, "R8 writing 0 to arm ignored");

    // R9: completion disarms and restores ready
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 2'b00, 1'b0, 8'h0, 1'b1);
    chk({15'd0, irq_out}, 16'h1, "R9 irq_out after done");
    rd_chk(8'hB0, 16'h0001, "R9 status after done");
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 2'b00, 1'b0, 8'h0, 1'b1);
    chk({15'd0, tx_start}, 16'h0, "R9 idle done no start");
    rd_chk(8'hB0, 16'h0001, "R9 idle done ignored");

    // R11: completion and re-arm in one cycle
    wr(8'hB0, 16'h0002, 2'b01);
    @(negedge clk);
    chk({15'd0, tx_start}, 16'h1, "R11 first start");
    cyc(1'b1, 1'b0, 8'hB0, 16'h0003, 2'b01, 1'b0, 8'h0, 1'b1);
    chk({15'd0, tx_start}, 16'h0, "R11 no start at done edge");
    @(negedge clk);
    chk({15'd0, tx_start}, 16'h1, "R11 restart pulse");
    rd_chk(8'hB0, 16'h0002, "R11 armed again");
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 2'b00, 1'b0, 8'h0, 1'b1);
    rd_chk(8'hB0, 16'h0001, "R11 second completion");

    // R5: arrival and clear of data-ready in the same cycle
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 2'b00, 1'b1, 8'h11, 1'b0);
    cyc(1'b1, 1'b0, 8'hA0, 16'h0000, 2'b01, 1'b1, 8'h22, 1'b0);
    chk({15'd0, irq_in}, 16'h1, "R5 irq_in held");
    rd_chk(8'hA0, 16'h0001, "R5 ready kept, no overrun");
    rd_chk(8'hA1, 16'h0022, "R5 new byte stored");
    wr(8'hA0, 16'h0000, 2'b01);
    rd_chk(8'hA0, 16'h0000, "R4 clear after collision");

    // R1: reset from a dirty state
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 2'b00, 1'b1, 8'h77, 1'b0);
    wr(8'hB1, 16'hFFFF, 2'b11);
    wr(8'hB0, 16'h0000, 2'b01);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk({14'd0, irq_out, irq_in}, 16'h0002, "R1 irq after reset");
    rd_chk(8'hA0, 16'h0000, "R1 rx status");
    rd_chk(8'hA1, 16'h0000, "R1 rx data");
    rd_chk(8'hB0, 16'h0001, "R1 tx status");
    rd_chk(8'hB1, 16'h0000, "R1 tx word");

    finish_run();
  end
endmodule